// File: doc/BRIEF.md
# Serial Audio Port, Slave Mode

This block joins a stereo codec core to an external serial audio link whose bit clock and frame clock are both driven by another device. Each frame holds a left and a right slot. On the serial data input the block collects one word per slot and passes the pair to the core on a parallel port. On the serial data output it sends the pair that the core offers on a second parallel port. Three framing styles share a single bit counter and a single window decoder: the two-channel inter-IC sound layout, left-justified and right-justified. The word length can be 16, 18, 20 or 24 bits.

A system clock that runs much faster than the link samples both link clocks and the input data. Synchronisers and edge detectors turn the bit clock into single-cycle rise and fall events. The bit counter restarts on every level change of the frame clock. From the selected framing and word length the block finds the window of the slot that carries data. Bits shift in on rise events and shift out on fall events. A parameter picks how received words reach the core: sign-extended, or aligned to the most significant bit.

Top module: `sap_slave_port`

## Requirements
- R1: Bit index 0 of a slot is the first bit-clock rising edge after a level change of the frame clock. The MSB sits at index 1 when fmt_sel is 0 (inter-IC sound), at index 0 when it is 1 (left-justified), and at index SLOT_W minus the word length when it is 2 or 3 (right-justified). Further bits follow MSB first in both directions.
- R2: wlen_sel codes 0, 1, 2 and 3 select 16, 18, 20 and 24 bits. Exactly that many bits per slot are received and transmitted.
- R3: With fmt_sel 0, a low frame clock marks the left slot. With every other fmt_sel value, a high frame clock marks the left slot.
- R4: With ALIGN_MSB 0, received words are sign-extended to SAMPLE_W bits. With ALIGN_MSB 1, they are placed in the top bits and the low bits are zero.
- R5: rx_valid pulses for exactly one cycle per frame, after the last data bit of the right slot. rx_left and rx_right change only in that cycle.
- R6: The frame clock and sdin are taken at bit-clock rising edges. sdout changes only after a detected bit-clock falling edge, so it is stable at the next rising edge.
- R7: sdout is 0 at every slot position outside the data window.
- R8: tx_take pulses once at the falling edge that opens a left slot. tx_left and tx_right are latched then, and later changes on those inputs do not affect the frame in progress.
- R9: sdin bits outside the data window have no effect on the received words.
- R10: During reset, and after reset until the first frame clock change, sdout, rx_valid and tx_take stay 0 and rx_left and rx_right read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the link |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk_in | input | 1 | External bit clock |
| fclk_in | input | 1 | External frame clock |
| sdin | input | 1 | Serial playback data |
| fmt_sel | input | 2 | Framing: 0 inter-IC sound, 1 left-justified, 2/3 right-justified |
| wlen_sel | input | 2 | Word length: 0=16, 1=18, 2=20, 3=24 bits |
| tx_left | input | SAMPLE_W | Left sample to transmit, LSB-aligned (ALIGN_MSB 0) or MSB-aligned (1) |
| tx_right | input | SAMPLE_W | Right sample to transmit, same alignment |
| tx_take | output | 1 | One-cycle strobe: transmit pair latched |
| sdout | output | 1 | Serial record data |
| rx_left | output | SAMPLE_W | Last received left word |
| rx_right | output | SAMPLE_W | Last received right word |
| rx_valid | output | 1 | One-cycle strobe: new received pair |

## Verification
The bench builds two copies with SAMPLE_W 24, SLOT_W 32 and SYNC_STAGES 2. One copy has ALIGN_MSB 0 and the other has ALIGN_MSB 1, so both ways of presenting received words are checked against the same serial traffic. With a 32-clock slot and the 24-bit maximum word, the inter-IC sound window ends at index 24 and the right-justified MSB falls at 8, 12, 14 or 16. The stimulus therefore reaches every MSB offset and the last slot bit. Changing framings between frames also flips the frame clock polarity, which the bench covers with a short filler slot.

// File: rtl/sap_pkg.sv
package sap_pkg;

   typedef enum logic [1:0] {
      SAP_FMT_IIS   = 2'd0,
      SAP_FMT_LJ    = 2'd1,
      SAP_FMT_RJ    = 2'd2,
      SAP_FMT_RJ_B  = 2'd3
   } sap_fmt_e;

   // word length code -> number of bits per slot
   function automatic int unsigned word_bits(input logic [1:0] code);
      case (code)
         2'd0:    return 16;
         2'd1:    return 18;
         2'd2:    return 20;
         default: return 24;
      endcase
   endfunction

   // slot index of the most significant bit
   function automatic int unsigned msb_slot_pos(input logic [1:0] fmt,
                                                input logic [1:0] code,
                                                input int unsigned slot_w);
      if (fmt == SAP_FMT_IIS)     return 1;
      else if (fmt == SAP_FMT_LJ) return 0;
      else                        return slot_w - word_bits(code);
   endfunction

   // 1 when this frame clock level marks the right slot
   function automatic logic level_is_right(input logic [1:0] fmt, input logic fclk);
      if (fmt == SAP_FMT_IIS) return fclk;
      else                    return ~fclk;
   endfunction

endpackage

// File: rtl/sap_sync_edge.sv
module sap_sync_edge #(
   parameter int STAGES = 2,
   parameter int LANES  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] async_in,
   output logic [LANES-1:0] sync_out,
   output logic             lane0_rise,
   output logic             lane0_fall
);
   localparam int CHAIN_W = STAGES * LANES;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sap_sync_edge: STAGES must be at least 2");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("sap_sync_edge: LANES must be at least 1");
      end
   endgenerate

   logic [CHAIN_W-1:0] chain_q;
   logic               lane0_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q      <= '0;
         lane0_prev_q <= 1'b0;
      end else begin
         chain_q      <= {chain_q[CHAIN_W-LANES-1:0], async_in};
         lane0_prev_q <= sync_out[0];
      end
   end

   assign sync_out   = chain_q[CHAIN_W-1 -: LANES];
   assign lane0_rise =  sync_out[0] & ~lane0_prev_q;
   assign lane0_fall = ~sync_out[0] &  lane0_prev_q;

endmodule

// File: rtl/sap_slot_timer.sv
module sap_slot_timer
   import sap_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int SLOT_W   = 32,
   parameter int CW       = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rise_evt,
   input  logic          fclk_s,
   input  logic [1:0]    fmt_sel,
   input  logic [1:0]    wlen_sel,
   output logic          nxt_start,
   output logic          nxt_right,
   output logic          nxt_ok,
   output logic          in_win,
   output logic          is_last,
   output logic [CW-1:0] bit_ofs,
   output logic [7:0]    shamt,
   output logic          locked
);
   localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
   localparam logic [CW-1:0] ONE     = CW'(1);

   logic          fclk_q;
   logic          right_q;
   logic          locked_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] nxt_idx;
   logic [CW-1:0] wb;
   logic [CW-1:0] msb;
   logic [CW-1:0] win_end;

   // index and channel that the coming bit-clock edge belongs to
   always_comb begin
      nxt_start = (fclk_s != fclk_q);
      nxt_ok    = locked_q | nxt_start;
      if (nxt_start)            nxt_idx = '0;
      else if (cnt_q == CNT_MAX) nxt_idx = cnt_q;
      else                      nxt_idx = cnt_q + ONE;
      nxt_right = nxt_start ? level_is_right(fmt_sel, fclk_s) : right_q;
   end

   // data window of the slot
   always_comb begin
      wb      = CW'(word_bits(wlen_sel));
      msb     = CW'(msb_slot_pos(fmt_sel, wlen_sel, SLOT_W));
      win_end = msb + wb;
      in_win  = (nxt_idx >= msb) && (nxt_idx < win_end);
      is_last = in_win && (nxt_idx == (win_end - ONE));
      bit_ofs = nxt_idx - msb;
      shamt   = 8'(SAMPLE_W - int'(word_bits(wlen_sel)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fclk_q   <= 1'b0;
         right_q  <= 1'b0;
         locked_q <= 1'b0;
         cnt_q    <= '0;
      end else if (rise_evt) begin
         fclk_q  <= fclk_s;
         right_q <= nxt_right;
         cnt_q   <= nxt_idx;
         if (nxt_start) locked_q <= 1'b1;
      end
   end

   assign locked = locked_q;

endmodule

// File: rtl/sap_rx_deser.sv
module sap_rx_deser #(
   parameter int SAMPLE_W  = 24,
   parameter int ALIGN_MSB = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rise_evt,
   input  logic                sdin_s,
   input  logic                nxt_ok,
   input  logic                nxt_right,
   input  logic                in_win,
   input  logic                is_last,
   input  logic [7:0]          shamt,
   output logic [SAMPLE_W-1:0] rx_left,
   output logic [SAMPLE_W-1:0] rx_right,
   output logic                rx_valid
);
   logic [SAMPLE_W-2:0] shift_q;
   logic [SAMPLE_W-1:0] hold_l_q;
   logic [SAMPLE_W-1:0] left_q;
   logic [SAMPLE_W-1:0] right_q;
   logic                valid_q;
   logic [SAMPLE_W-1:0] word_raw;
   logic [SAMPLE_W-1:0] word_top;
   logic [SAMPLE_W-1:0] word_out;

   assign word_raw = {shift_q, sdin_s};
   assign word_top = word_raw << shamt;

   generate
      if (ALIGN_MSB == 0) begin : g_sign_ext
         logic signed [SAMPLE_W-1:0] top_s;
         assign top_s    = word_top;
         assign word_out = top_s >>> shamt;
      end else begin : g_msb_align
         assign word_out = word_top;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q  <= '0;
         hold_l_q <= '0;
         left_q   <= '0;
         right_q  <= '0;
         valid_q  <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (rise_evt && nxt_ok && in_win) begin
            shift_q <= word_raw[SAMPLE_W-2:0];
            if (is_last) begin
               if (nxt_right) begin
                  left_q  <= hold_l_q;
                  right_q <= word_out;
                  valid_q <= 1'b1;
               end else begin
                  hold_l_q <= word_out;
               end
            end
         end
      end
   end

   assign rx_left  = left_q;
   assign rx_right = right_q;
   assign rx_valid = valid_q;

endmodule

// File: rtl/sap_tx_ser.sv
module sap_tx_ser #(
   parameter int SAMPLE_W  = 24,
   parameter int CW        = 6,
   parameter int ALIGN_MSB = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fall_evt,
   input  logic                nxt_ok,
   input  logic                nxt_start,
   input  logic                nxt_right,
   input  logic                in_win,
   input  logic [CW-1:0]       bit_ofs,
   input  logic [7:0]          shamt,
   input  logic [SAMPLE_W-1:0] tx_left,
   input  logic [SAMPLE_W-1:0] tx_right,
   output logic                sdout,
   output logic                tx_take
);
   logic [SAMPLE_W-1:0] hold_l_q;
   logic [SAMPLE_W-1:0] hold_r_q;
   logic                sdout_q;
   logic                take_q;
   logic                load;
   logic [SAMPLE_W-1:0] src;
   logic [SAMPLE_W-1:0] vec;
   logic [SAMPLE_W-1:0] vec_sh;
   logic                bit_nxt;

   assign load = nxt_ok && nxt_start && !nxt_right;

   always_comb begin
      if (load)           src = tx_left;
      else if (nxt_right) src = hold_r_q;
      else                src = hold_l_q;
   end

   generate
      if (ALIGN_MSB == 0) begin : g_lsb_src
         assign vec = src << shamt;
      end else begin : g_msb_src
         assign vec = src;
      end
   endgenerate

   assign vec_sh  = vec << bit_ofs;
   assign bit_nxt = nxt_ok && in_win && vec_sh[SAMPLE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_l_q <= '0;
         hold_r_q <= '0;
         sdout_q  <= 1'b0;
         take_q   <= 1'b0;
      end else begin
         take_q <= 1'b0;
         if (fall_evt) begin
            sdout_q <= bit_nxt;
            if (load) begin
               hold_l_q <= tx_left;
               hold_r_q <= tx_right;
               take_q   <= 1'b1;
            end
         end
      end
   end

   assign sdout   = sdout_q;
   assign tx_take = take_q;

endmodule

// File: rtl/sap_slave_port.sv
module sap_slave_port #(
   parameter int SAMPLE_W    = 24,
   parameter int SLOT_W      = 32,
   parameter int SYNC_STAGES = 2,
   parameter int ALIGN_MSB   = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bclk_in,
   input  logic                fclk_in,
   input  logic                sdin,
   input  logic [1:0]          fmt_sel,
   input  logic [1:0]          wlen_sel,
   input  logic [SAMPLE_W-1:0] tx_left,
   input  logic [SAMPLE_W-1:0] tx_right,
   output logic                tx_take,
   output logic                sdout,
   output logic [SAMPLE_W-1:0] rx_left,
   output logic [SAMPLE_W-1:0] rx_right,
   output logic                rx_valid
);
   localparam int CW    = $clog2(SLOT_W) + 1;
   localparam int LANES = 3;

   generate
      if (SAMPLE_W < 24) begin : g_bad_sample
         $error("sap_slave_port: SAMPLE_W must hold a 24-bit word");
      end
      if (SLOT_W < SAMPLE_W + 1) begin : g_bad_slot
         $error("sap_slave_port: SLOT_W must exceed SAMPLE_W");
      end
      if (ALIGN_MSB != 0 && ALIGN_MSB != 1) begin : g_bad_align
         $error("sap_slave_port: ALIGN_MSB must be 0 or 1");
      end
   endgenerate

   logic [LANES-1:0] lanes_s;
   logic             rise_evt;
   logic             fall_evt;
   logic             nxt_start;
   logic             nxt_right;
   logic             nxt_ok;
   logic             in_win;
   logic             is_last;
   logic [CW-1:0]    bit_ofs;
   logic [7:0]       shamt;
   logic             locked;

   sap_sync_edge #(
      .STAGES (SYNC_STAGES),
      .LANES  (LANES)
   ) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .async_in   ({sdin, fclk_in, bclk_in}),
      .sync_out   (lanes_s),
      .lane0_rise (rise_evt),
      .lane0_fall (fall_evt)
   );

   sap_slot_timer #(
      .SAMPLE_W (SAMPLE_W),
      .SLOT_W   (SLOT_W),
      .CW       (CW)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise_evt  (rise_evt),
      .fclk_s    (lanes_s[1]),
      .fmt_sel   (fmt_sel),
      .wlen_sel  (wlen_sel),
      .nxt_start (nxt_start),
      .nxt_right (nxt_right),
      .nxt_ok    (nxt_ok),
      .in_win    (in_win),
      .is_last   (is_last),
      .bit_ofs   (bit_ofs),
      .shamt     (shamt),
      .locked    (locked)
   );

   sap_rx_deser #(
      .SAMPLE_W  (SAMPLE_W),
      .ALIGN_MSB (ALIGN_MSB)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise_evt  (rise_evt),
      .sdin_s    (lanes_s[2]),
      .nxt_ok    (nxt_ok),
      .nxt_right (nxt_right),
      .in_win    (in_win),
      .is_last   (is_last),
      .shamt     (shamt),
      .rx_left   (rx_left),
      .rx_right  (rx_right),
      .rx_valid  (rx_valid)
   );

   sap_tx_ser #(
      .SAMPLE_W  (SAMPLE_W),
      .CW        (CW),
      .ALIGN_MSB (ALIGN_MSB)
   ) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .fall_evt  (fall_evt),
      .nxt_ok    (nxt_ok),
      .nxt_start (nxt_start),
      .nxt_right (nxt_right),
      .in_win    (in_win),
      .bit_ofs   (bit_ofs),
      .shamt     (shamt),
      .tx_left   (tx_left),
      .tx_right  (tx_right),
      .sdout     (sdout),
      .tx_take   (tx_take)
   );

endmodule

// File: rtl/sap_slave_port_chk.sv
module sap_slave_port_chk
   import sap_pkg::*;
#(
   parameter int SAMPLE_W  = 24,
   parameter int ALIGN_MSB = 0
) (
   input logic                clk,
   input logic                rst_n,
   input logic [1:0]          wlen_sel,
   input logic                rx_valid,
   input logic [SAMPLE_W-1:0] rx_left,
   input logic [SAMPLE_W-1:0] rx_right,
   input logic                tx_take,
   input logic                sdout,
   input logic                fall_evt,
   input logic                locked
);
   function automatic logic word_ok(input logic [SAMPLE_W-1:0] x, input logic [1:0] code);
      logic signed [SAMPLE_W-1:0] t;
      if (ALIGN_MSB == 0) begin
         t = $signed(x) >>> (word_bits(code) - 1);
         return (t == '0) || (t == '1);
      end else begin
         return (x << word_bits(code)) == '0;
      end
   endfunction

   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);                                          // R5
   AST_PAIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> ($stable(rx_left) && $stable(rx_right)));           // R5
   AST_WORD_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> (word_ok(rx_left, wlen_sel) && word_ok(rx_right, wlen_sel))); // R4
   AST_SDOUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdout) |-> $past(fall_evt));                             // R6
   AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_take |=> !tx_take);                                            // R8
   AST_QUIET_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |-> (!sdout && !rx_valid && !tx_take));                   // R10

endmodule

bind sap_slave_port sap_slave_port_chk #(
   .SAMPLE_W  (SAMPLE_W),
   .ALIGN_MSB (ALIGN_MSB)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wlen_sel (wlen_sel),
   .rx_valid (rx_valid),
   .rx_left  (rx_left),
   .rx_right (rx_right),
   .tx_take  (tx_take),
   .sdout    (sdout),
   .fall_evt (fall_evt),
   .locked   (locked)
);

// File: tb/sap_slave_port_bench.sv
module sap_slave_port_bench;

   localparam int HALF = 8;            // system clocks per bit-clock half period
   localparam int WD_CYCLES = 150000;

   // {fmt, wlen, rx left, rx right, tx left, tx right}
   localparam logic [99:0] VEC_TAB [8] = '{
      {2'd0, 2'd3, 24'h800001, 24'h7FFFFE, 24'hA5C396, 24'h5A3C69},
      {2'd1, 2'd0, 24'h008123, 24'h007ABC, 24'h12F00F, 24'hFF1234},
      {2'd2, 2'd1, 24'h020001, 24'h015555, 24'h03AAAA, 24'h00C0DE},
      {2'd3, 2'd2, 24'h081234, 24'h07FFFF, 24'hF00F0F, 24'h0FF0F0},
      {2'd2, 2'd3, 24'hC0FFEE, 24'h3F0011, 24'h800000, 24'h000001},
      {2'd0, 2'd0, 24'hFFFFFF, 24'h000000, 24'h00FFFF, 24'h008000},
      {2'd1, 2'd3, 24'h123456, 24'hEDCBA9, 24'hDEADBE, 24'h0BEEF0},
      {2'd0, 2'd2, 24'h0ABCDE, 24'h054321, 24'h13579B, 24'h2468AC}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk_in = 1'b1;
   logic        fclk_in = 1'b0;
   logic        sdin = 1'b0;
   logic [1:0]  fmt_sel = 2'd0;
   logic [1:0]  wlen_sel = 2'd3;
   logic [23:0] tx_left = '0;
   logic [23:0] tx_right = '0;

   logic        take_a, sd_a, vld_a;
   logic [23:0] rl_a, rr_a;
   logic        take_b, sd_b, vld_b;
   logic [23:0] rl_b, rr_b;

   int n_chk = 0;
   int n_bad = 0;
   int nva = 0, nvb = 0, nta = 0;
   logic [23:0] cap_la, cap_ra, cap_lb, cap_rb;
   bit done = 0;

   always #2 clk = ~clk;

   sap_slave_port u_sap_slave_port (
      .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .fclk_in(fclk_in), .sdin(sdin),
      .fmt_sel(fmt_sel), .wlen_sel(wlen_sel), .tx_left(tx_left), .tx_right(tx_right),
      .tx_take(take_a), .sdout(sd_a), .rx_left(rl_a), .rx_right(rr_a), .rx_valid(vld_a));

   sap_slave_port #(.ALIGN_MSB(1)) u_sap_slave_port_la (
      .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .fclk_in(fclk_in), .sdin(sdin),
      .fmt_sel(fmt_sel), .wlen_sel(wlen_sel), .tx_left(tx_left), .tx_right(tx_right),
      .tx_take(take_b), .sdout(sd_b), .rx_left(rl_b), .rx_right(rr_b), .rx_valid(vld_b));

   always @(negedge clk) begin
      if (rst_n) begin
         if (vld_a) begin nva++; cap_la = rl_a; cap_ra = rr_a; end
         if (vld_b) begin nvb++; cap_lb = rl_b; cap_rb = rr_b; end
         if (take_a) nta++;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int bits_of(input logic [1:0] wl);
      case (wl)
         2'd0: return 16;
         2'd1: return 18;
         2'd2: return 20;
         default: return 24;
      endcase
   endfunction

   function automatic logic [23:0] sext(input logic [23:0] w, input int wb);
      logic signed [23:0] t;
      t = $signed(w << (24 - wb));
      return t >>> (24 - wb);
   endfunction

   task automatic bit_cycle(input logic lvl, input logic sd, output logic oa, output logic ob);
      @(negedge clk);
      bclk_in = 1'b0;
      fclk_in = lvl;
      sdin    = sd;
      repeat (HALF - 1) @(negedge clk);
      oa = sd_a;
      ob = sd_b;
      @(negedge clk);
      bclk_in = 1'b1;
      repeat (HALF - 1) @(negedge clk);
   endtask

   task automatic play(input logic [1:0] f, input logic [1:0] wl,
                       input logic [23:0] rl, input logic [23:0] rr,
                       input logic [23:0] tl, input logic [23:0] tr,
                       input bit ones_fill);
      int          wb;
      int          mp;
      int          va0, vb0, ta0;
      logic        left_lvl;
      logic        oa, ob, lvl, sd;
      logic [23:0] w, txw;
      logic [31:0] act_a [2];
      logic [31:0] act_b [2];
      logic [31:0] exp_a [2];
      logic [31:0] exp_b [2];
      logic [31:0] mask;
      wb  = bits_of(wl);
      mp  = (f == 2'd0) ? 1 : ((f == 2'd1) ? 0 : 32 - wb);
      left_lvl = (f == 2'd0) ? 1'b0 : 1'b1;
      va0 = nva; vb0 = nvb; ta0 = nta;
      mask = '0;
      for (int i = 0; i < 32; i++) if (i >= mp && i < mp + wb) mask[31-i] = 1'b1;
      fmt_sel = f; wlen_sel = wl; tx_left = tl; tx_right = tr;
      if (fclk_in == left_lvl) begin
         for (int k = 0; k < 4; k++) bit_cycle(~left_lvl, 1'b1, oa, ob);
      end
      for (int ch = 0; ch < 2; ch++) begin
         lvl = (ch == 0) ? left_lvl : ~left_lvl;
         w   = (ch == 0) ? rl : rr;
         txw = (ch == 0) ? tl : tr;
         act_a[ch] = '0; act_b[ch] = '0; exp_a[ch] = '0; exp_b[ch] = '0;
         for (int i = 0; i < 32; i++) begin
            int d;
            d = i - mp;
            if (d >= 0 && d < wb) begin
               sd = w[wb-1-d];
               exp_a[ch][31-i] = txw[wb-1-d];
               exp_b[ch][31-i] = txw[23-d];
            end else begin
               sd = ones_fill ? 1'b1 : logic'(i % 2);
            end
            if (ch == 0 && i == 3) begin   // late change must not reach this frame (R8)
               tx_left  = ~tl;
               tx_right = ~tr;
            end
            bit_cycle(lvl, sd, oa, ob);
            act_a[ch][31-i] = oa;
            act_b[ch][31-i] = ob;
         end
      end
      for (int ch = 0; ch < 2; ch++) begin
         check("R1 tx window", act_a[ch] & mask, exp_a[ch] & mask);
         check("R6 tx window msb-aligned", act_b[ch] & mask, exp_b[ch] & mask);
         check("R7 tx outside window", (act_a[ch] | act_b[ch]) & ~mask, 32'd0);
      end
      check("R5 rx_valid count", 32'(nva - va0), 32'd1);
      check("R5 rx_valid count msb-aligned", 32'(nvb - vb0), 32'd1);
      check("R8 tx_take count", 32'(nta - ta0), 32'd1);
      check("R3 rx left", {8'd0, cap_la}, {8'd0, sext(rl, wb)});
      check("R2 rx right", {8'd0, cap_ra}, {8'd0, sext(rr, wb)});
      check("R4 rx left msb-aligned", {8'd0, cap_lb}, {8'd0, rl << (24 - wb)});
      check("R4 rx right msb-aligned", {8'd0, cap_rb}, {8'd0, rr << (24 - wb)});
   endtask

   initial begin
      logic oa, ob;
      logic [99:0] v;
      logic any_out;
      int va0, ta0;
      repeat (10) @(negedge clk);
      // R10: reset state
      check("R10 reset sdout", {31'd0, sd_a | sd_b}, 32'd0);
      check("R10 reset strobes", {30'd0, vld_a | vld_b, take_a | take_b}, 32'd0);
      check("R10 reset rx words", {8'd0, rl_a | rr_a | rl_b | rr_b}, 32'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      for (int k = 0; k < 8; k++) begin
         v = VEC_TAB[k];
         play(v[99:98], v[97:96], v[95:72], v[71:48], v[47:24], v[23:0], 1'b0);
      end

      // R9: bits outside the window are all ones, words are zero / minus one
      play(2'd1, 2'd0, 24'h000000, 24'h00FFFF, 24'h00F00F, 24'h000F00, 1'b1);
      check("R9 rx left zero despite fill", {8'd0, cap_la}, 32'd0);
      play(2'd2, 2'd2, 24'h000000, 24'h000001, 24'h012345, 24'h0FEDCB, 1'b1);
      check("R9 rx left zero despite fill rj", {8'd0, cap_lb}, 32'd0);

      // R10: reset mid-run, then no frame clock change
      @(negedge clk);
      rst_n = 1'b0;
      fclk_in = 1'b0;
      repeat (5) @(negedge clk);
      check("R10 mid-run reset rx words", {8'd0, rl_a | rr_a | rl_b | rr_b}, 32'd0);
      rst_n = 1'b1;
      tx_left = 24'hFFFFFF; tx_right = 24'hFFFFFF;
      va0 = nva; ta0 = nta;
      any_out = 1'b0;
      for (int i = 0; i < 40; i++) begin
         bit_cycle(1'b0, 1'b1, oa, ob);
         any_out = any_out | oa | ob;
      end
      check("R10 sdout before lock", {31'd0, any_out}, 32'd0);
      check("R10 strobes before lock", 32'((nva - va0) + (nta - ta0)), 32'd0);
      play(2'd0, 2'd3, 24'h7FFFFF, 24'h800000, 24'h3C3C3C, 24'hC3C3C3, 1'b0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog R5 actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule